// File: doc/BRIEF.md
# Programmable I2C SCL Clock Generator

This block produces the SCL waveform for an I2C bus master that runs from a 4 MHz system clock. A 5-bit divider code and a speed-mode bit set the bus clock rate. In standard mode the rate is 500 kHz divided by the code. In fast mode it is 1000 kHz divided by the code. One fast-mode code is a special case: it gives 400 kHz with a 40% high time instead of following the divider law.

The block does not drive the bus pin itself. It asks for SCL to be pulled low through `scl_low`, and it pulses `scl_fall` or `scl_rise` for one cycle whenever it changes that request. Codes that are too small for the selected mode are refused: SCL stays released and `cfg_err` is raised. Once generation has started, a change of code or mode is taken up only at the next falling edge. A stop request is honoured only at the end of a high phase. Both rules keep the phases whole.

Top module: `scl_clock_gen`

## Requirements
- R1: After synchronous reset, `scl_low`, `scl_rise`, `scl_fall` and `cfg_err` are all 0.
- R2: In standard mode (`fast_mode`=0) with a legal code N (5..31), every low phase and every high phase lasts 4*N system clocks. Code 5 gives 20/20 and code 31 gives 124/124.
- R3: In fast mode (`fast_mode`=1) with a legal code N other than 5 (3, 4, 6..31), each phase lasts 2*N clocks. Code 3 gives 6/6, code 4 gives 8/8 and code 31 gives 62/62.
- R4: In fast mode, code 5 gives a low phase of 6 clocks and a high phase of 4 clocks.
- R5: Codes 0..4 are illegal in standard mode and codes 0..2 are illegal in fast mode. While an illegal setting is applied with `en`=1, `cfg_err` is 1 from the following clock on, SCL stays released and no strobe occurs. `cfg_err` is 0 for a legal setting.
- R6: `scl_fall` is a one-cycle pulse in the cycle where `scl_low` becomes 1. `scl_rise` is a one-cycle pulse in the cycle where `scl_low` becomes 0. The two never pulse together.
- R7: A code or mode change made while running leaves the current low and high phases unchanged. It sets the timing from the next falling edge on.
- R8: When `run` is 0 at the end of a high phase, no further falling edge is produced and SCL stays released. A phase already under way completes first.
- R9: With `en`=0, from the next clock on `scl_low`=0, no strobe occurs and `cfg_err`=0, whatever the phase was.
- R10: From idle, when `en`=1, `run`=1 and a legal setting are sampled at a clock edge, that same edge produces a falling edge (`scl_fall`=1, `scl_low`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 releases SCL at once |
| run | input | 1 | Request to generate clock edges |
| div_code | input | 5 | Divider code |
| fast_mode | input | 1 | 0 = standard law, 1 = fast law |
| scl_low | output | 1 | 1 = pull SCL low |
| scl_rise | output | 1 | One-cycle strobe at each SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe at each SCL falling edge |
| cfg_err | output | 1 | Applied code is illegal for the mode |

## Verification
On every cycle, the assertions check how the strobes relate to `scl_low`:
- each strobe coincides with the matching level change,
- the two strobes never overlap,
- the level is never released without a rise strobe unless the block was disabled,
- no falling edge is ever produced while `cfg_err` is set,
- a disabled block stays quiet.

Only the bench scenarios can show the actual phase lengths for each law and for the 400 kHz case. The same holds for the moment a mid-run change takes effect and for the clean stop at the end of a high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_t;
endpackage

// File: rtl/scl_cfg_decode.sv
// Turns the divider code and mode into phase lengths and a legality flag.
module scl_cfg_decode #(
  parameter int CODE_W    = 5,
  parameter int CNT_W     = 7,
  parameter int STD_MUL   = 4,
  parameter int FAST_MUL  = 2,
  parameter int STD_MIN   = 5,
  parameter int FAST_MIN  = 3,
  parameter int SPEC_CODE = 5,
  parameter int SPEC_HIGH = 4,
  parameter int SPEC_LOW  = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic              fast,
  output logic              legal,
  output logic [CNT_W-1:0]  low_len,
  output logic [CNT_W-1:0]  high_len
);
  logic [CNT_W-1:0] base_len;
  logic             special;

  always_comb begin
    legal    = fast ? (code >= CODE_W'(FAST_MIN)) : (code >= CODE_W'(STD_MIN));
    special  = fast && (code == CODE_W'(SPEC_CODE));
    base_len = CNT_W'(code) * (fast ? CNT_W'(FAST_MUL) : CNT_W'(STD_MUL));
    low_len  = special ? CNT_W'(SPEC_LOW)  : base_len;
    high_len = special ? CNT_W'(SPEC_HIGH) : base_len;
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
// Low/high phase sequencer with registered level and edge strobes.
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             legal,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  output logic             scl_low,
  output logic             scl_rise,
  output logic             scl_fall
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  scl_phase_t       phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] high_hold;
  logic             go;

  assign go = run && legal;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      high_hold <= '0;
      scl_low   <= 1'b0;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
    end else begin
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (go) begin
            phase     <= PH_LOW;
            scl_low   <= 1'b1;
            scl_fall  <= 1'b1;
            cnt       <= low_len - ONE;
            high_hold <= high_len;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            phase    <= PH_HIGH;
            scl_low  <= 1'b0;
            scl_rise <= 1'b1;
            cnt      <= high_hold - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            if (go) begin
              phase     <= PH_LOW;
              scl_low   <= 1'b1;
              scl_fall  <= 1'b1;
              cnt       <= low_len - ONE;
              high_hold <= high_len;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: strobes never coincide
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise && scl_fall));
  // R6: a fall strobe comes with the low request
  a_r6_fall_with_low: assert property (@(posedge clk) disable iff (rst)
    scl_fall |-> scl_low);
  // R6: a rise strobe comes with the release
  a_r6_rise_with_release: assert property (@(posedge clk) disable iff (rst)
    scl_rise |-> !scl_low);
  // R6: the low request only starts with a fall strobe
  a_r6_low_starts_by_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_low) |-> scl_fall);
  // R6/R9: release happens with a rise strobe or through disable
  a_r9_release_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_low) |-> (scl_rise || !$past(en)));
  // R9: a disabled block is quiet on the next cycle
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_low && !scl_rise && !scl_fall));
endmodule

// File: rtl/scl_clock_gen.sv
// Top: SCL clock generator with two divider laws and a fixed-length fast case.
module scl_clock_gen #(
  parameter int CODE_W    = 5,
  parameter int STD_MUL   = 4,
  parameter int FAST_MUL  = 2,
  parameter int STD_MIN   = 5,
  parameter int FAST_MIN  = 3,
  parameter int SPEC_CODE = 5,
  parameter int SPEC_HIGH = 4,
  parameter int SPEC_LOW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              run,
  input  logic [CODE_W-1:0] div_code,
  input  logic              fast_mode,
  output logic              scl_low,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              cfg_err
);
  localparam int MAX_LEN = STD_MUL * ((1 << CODE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             legal;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;

  scl_cfg_decode #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .STD_MUL(STD_MUL), .FAST_MUL(FAST_MUL),
    .STD_MIN(STD_MIN), .FAST_MIN(FAST_MIN), .SPEC_CODE(SPEC_CODE),
    .SPEC_HIGH(SPEC_HIGH), .SPEC_LOW(SPEC_LOW)
  ) u_dec (
    .code(div_code), .fast(fast_mode), .legal(legal),
    .low_len(low_len), .high_len(high_len)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .en(en), .run(run), .legal(legal),
    .low_len(low_len), .high_len(high_len),
    .scl_low(scl_low), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= en && !legal;
  end

  // R5: no falling edge is produced while the error flag is up
  a_r5_no_fall_on_error: assert property (@(posedge clk) disable iff (rst)
    scl_fall |-> !cfg_err);
  // R9: disabling clears the error flag
  a_r9_error_cleared: assert property (@(posedge clk) disable iff (rst)
    !en |=> !cfg_err);
endmodule

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       run = 1'b0;
  logic [4:0] div_code = 5'd0;
  logic       fast_mode = 1'b0;
  logic       scl_low, scl_rise, scl_fall, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_clock_gen u0 (
    .clk(clk), .rst(rst), .en(en), .run(run), .div_code(div_code),
    .fast_mode(fast_mode), .scl_low(scl_low), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 2000 && !scl_fall; i++) @(negedge clk);
  endtask

  // Called at a fall-strobe sample; returns at the next fall-strobe sample.
  task automatic phase_lens(output int lo, output int hi);
    lo = 0;
    hi = 0;
    while (!scl_rise && lo < 1000) begin lo++; @(negedge clk); end
    while (!scl_fall && hi < 1000) begin hi++; @(negedge clk); end
  endtask

  task automatic go_idle();
    en  = 1'b0;
    run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start(input bit f, input int code);
    fast_mode = f;
    div_code  = 5'(code);
    en        = 1'b1;
    run       = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!scl_low && !scl_rise && !scl_fall && !cfg_err, "R1 reset outputs",
        {scl_low, scl_rise, scl_fall, cfg_err}, 0);
  endtask

  task automatic t_start_and_std5();
    int lo, hi;
    start(1'b0, 5);
    chk(scl_fall && scl_low, "R10 first edge is a fall", {scl_fall, scl_low}, 3);
    phase_lens(lo, hi);
    chk(lo == 20, "R2 std code 5 low", lo, 20);
    chk(hi == 20, "R2 std code 5 high", hi, 20);
    @(negedge clk);
    chk(!scl_fall && scl_low, "R6 fall strobe lasts one cycle", scl_fall, 0);
    go_idle();
  endtask

  task automatic t_len(input bit f, input int code, input int elo, input int ehi,
                       input string req);
    int lo, hi;
    start(f, code);
    phase_lens(lo, hi);
    phase_lens(lo, hi);
    chk(lo == elo, req, lo, elo);
    chk(hi == ehi, req, hi, ehi);
    go_idle();
  endtask

  task automatic t_illegal(input bit f, input int code);
    int acts;
    acts = 0;
    start(f, code);
    chk(cfg_err, "R5 error flag raised", cfg_err, 1);
    for (int i = 0; i < 100; i++) begin
      if (scl_low || scl_rise || scl_fall) acts++;
      @(negedge clk);
    end
    chk(acts == 0, "R5 no activity on illegal code", acts, 0);
    go_idle();
  endtask

  task automatic t_change();
    int lo, hi;
    start(1'b0, 5);
    div_code = 5'd6;
    phase_lens(lo, hi);
    chk(lo == 20 && hi == 20, "R7 current phases keep old code", lo + hi, 40);
    fast_mode = 1'b1;
    div_code  = 5'd5;
    phase_lens(lo, hi);
    chk(lo == 24 && hi == 24, "R7 new code after next fall", lo + hi, 48);
    phase_lens(lo, hi);
    chk(lo == 6 && hi == 4, "R7 R4 mode switch to fast 400k", lo * 100 + hi, 604);
    go_idle();
  endtask

  task automatic t_stop();
    int lo, falls;
    lo = 0;
    falls = 0;
    start(1'b0, 5);
    run = 1'b0;
    while (!scl_rise && lo < 1000) begin lo++; @(negedge clk); end
    chk(lo == 20, "R8 low phase completes after stop request", lo, 20);
    for (int i = 0; i < 300; i++) begin
      if (scl_fall || scl_low) falls++;
      @(negedge clk);
    end
    chk(falls == 0, "R8 no further fall, SCL released", falls, 0);
    go_idle();
  endtask

  task automatic t_disable();
    int acts;
    acts = 0;
    start(1'b0, 5);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_low && !scl_rise && !scl_fall, "R9 immediate release without strobe",
        {scl_low, scl_rise, scl_fall}, 0);
    for (int i = 0; i < 50; i++) begin
      if (scl_low || scl_rise || scl_fall || cfg_err) acts++;
      @(negedge clk);
    end
    chk(acts == 0, "R9 stays quiet while disabled", acts, 0);
    div_code = 5'd1;
    repeat (2) @(negedge clk);
    chk(!cfg_err, "R9 no error flag while disabled", cfg_err, 0);
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_start_and_std5();
    t_len(1'b0, 31, 124, 124, "R2 std code 31");
    t_len(1'b1, 3, 6, 6, "R3 fast code 3");
    t_len(1'b1, 4, 8, 8, "R3 R5 fast code 4 legal");
    t_len(1'b1, 31, 62, 62, "R3 fast code 31");
    t_len(1'b1, 5, 6, 4, "R4 fast code 5");
    t_illegal(1'b0, 4);
    t_illegal(1'b0, 0);
    t_illegal(1'b1, 2);
    start(1'b0, 6);
    chk(!cfg_err, "R5 legal code clears flag", cfg_err, 0);
    go_idle();
    t_change();
    t_stop();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule